// File: doc/BRIEF.md
# Balanced Random Bit-Stream Generator

This block produces the ±1 modulation bit that a background calibration engine multiplies into a converter's digital output before averaging. The bit has to look like white noise, yet over any session the number of ones and zeros must stay close to equal. Otherwise the averaged product keeps a residue from the input signal and from the quantization error.

A 23-bit maximal-length shift register supplies a raw pseudo-random bit on every enabled cycle. A signed running balance counts emitted ones minus emitted zeros. When the balance has drifted past the upper threshold, the next emitted bit is forced to 0. When it has drifted past the lower threshold, the next emitted bit is forced to 1. Otherwise the raw bit goes through unchanged. Loading a seed starts a new session: the balance goes back to zero and the shift register restarts from the given seed.

Top module: `bal_bitgen`

## Requirements
- R1: After reset is asserted (`rst_n` low), `bit_out` is 0, `balance` is 0 and the shift register holds the default seed 23'h000001.
- R2: On each advancing cycle, the raw bit is bit 22 of the shift register. The register then shifts toward bit 22 and takes `q[22] ^ q[17]` into bit 0 (polynomial x^23 + x^18 + 1).
- R3: On each advancing cycle, `balance` rises by 1 when the emitted bit is 1 and falls by 1 when it is 0. The emitted bit is the value after any override, and it appears on `bit_out` one clock after the cycle.
- R4: When `balance` is above +4 (upper threshold) on an advancing cycle, the emitted bit is 0 whatever the raw bit is.
- R5: When `balance` is below −4 (lower threshold) on an advancing cycle, the emitted bit is 1 whatever the raw bit is.
- R6: `balance` stays within −5 to +5 at all times.
- R7: When `en` is low and `seed_load` is low, `bit_out`, `balance` and the shift register all hold their values.
- R8: When `seed_load` is high, the next clock loads `seed` into the shift register and clears `balance` and `bit_out` to 0. This takes priority over `en`.
- R9: A seed of zero is replaced by the default seed 23'h000001, so the register never locks up.
- R10: When `balance` is between −4 and +4 inclusive on an advancing cycle, the emitted bit equals the raw bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Advance the stream by one bit this cycle |
| seed_load | input | 1 | Start a new session from `seed` |
| seed | input | 23 | Seed value for the shift register |
| bit_out | output | 1 | Emitted modulation bit |
| balance | output | 4 | Signed ones-minus-zeros count for the session |

## Verification
The checker watches, on every cycle, the properties that involve the balance: its range bound, its step of ±1 that follows the emitted bit, the forced value when the balance sits at either edge, pass-through of the raw bit inside the window, holding while idle, and the clear on a seed load. Only the bench's scenarios can show that the raw bits follow the stated polynomial from a given seed. The same goes for a zero seed being replaced, and for the shift register not advancing during idle cycles. To show these, the bench compares long emitted streams against its own model, started from seeds of all ones and of a single one so that both clamps are driven hard.

// File: rtl/bal_pkg.sv
package bal_pkg;

  typedef enum logic [1:0] {
    OVR_NONE = 2'd0,
    OVR_ZERO = 2'd1,
    OVR_ONE  = 2'd2
  } ovr_e;

  // Decide whether the running balance demands an override.
  function automatic ovr_e ovr_decide(int bal, int hi, int lo);
    if (bal > hi) return OVR_ZERO;
    if (bal < lo) return OVR_ONE;
    return OVR_NONE;
  endfunction

  // Apply an override decision to the raw bit.
  function automatic logic ovr_apply(logic raw, ovr_e o);
    case (o)
      OVR_ZERO: return 1'b0;
      OVR_ONE:  return 1'b1;
      default:  return raw;
    endcase
  endfunction

endpackage

// File: rtl/bal_lfsr.sv
module bal_lfsr #(
  parameter int              W        = 23,
  parameter int              TAP      = 18,
  parameter logic [W-1:0]    DEF_SEED = W'(1)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         adv,
  input  logic         load,
  input  logic [W-1:0] seed,
  output logic         raw,
  output logic         seed_zero
);

  localparam logic [W-1:0] SAFE_DEF = (DEF_SEED == '0) ? W'(1) : DEF_SEED;

  logic [W-1:0] q;

  function automatic logic [W-1:0] lfsr_next(logic [W-1:0] s);
    return {s[W-2:0], s[W-1] ^ s[TAP-1]};
  endfunction

  assign seed_zero = (seed == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      q <= SAFE_DEF;
    else if (load)   q <= seed_zero ? SAFE_DEF : seed;
    else if (adv)    q <= lfsr_next(q);
  end

  assign raw = q[W-1];

endmodule

// File: rtl/bal_tracker.sv
module bal_tracker
  import bal_pkg::*;
#(
  parameter int HI_TH = 4,
  parameter int LO_TH = -4,
  parameter int BAL_W = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    adv,
  input  logic                    clr,
  input  logic                    raw,
  output logic                    bit_out,
  output logic signed [BAL_W-1:0] balance,
  output logic                    force_hi,
  output logic                    force_lo
);

  ovr_e ovr;
  logic emit;

  assign ovr      = ovr_decide(int'(balance), HI_TH, LO_TH);
  assign emit     = ovr_apply(raw, ovr);
  assign force_hi = (ovr == OVR_ZERO);
  assign force_lo = (ovr == OVR_ONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_out <= 1'b0;
      balance <= '0;
    end else if (clr) begin
      bit_out <= 1'b0;
      balance <= '0;
    end else if (adv) begin
      bit_out <= emit;
      balance <= emit ? balance + BAL_W'(1) : balance - BAL_W'(1);
    end
  end

endmodule

// File: rtl/bal_bitgen.sv
module bal_bitgen #(
  parameter int                 LFSR_W   = 23,
  parameter int                 LFSR_TAP = 18,
  parameter logic [LFSR_W-1:0]  DEF_SEED = LFSR_W'(1),
  parameter int                 HI_TH    = 4,
  parameter int                 LO_TH    = -4,
  localparam int                BAL_W    = $clog2(HI_TH + 2) + 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    en,
  input  logic                    seed_load,
  input  logic [LFSR_W-1:0]       seed,
  output logic                    bit_out,
  output logic signed [BAL_W-1:0] balance
);

  // Named internal events for the checker.
  logic advance;
  logic raw_bit;
  logic seed_zero;
  logic force_hi;
  logic force_lo;

  assign advance = en & ~seed_load;

  bal_lfsr #(
    .W        (LFSR_W),
    .TAP      (LFSR_TAP),
    .DEF_SEED (DEF_SEED)
  ) u_lfsr (
    .clk       (clk),
    .rst_n     (rst_n),
    .adv       (advance),
    .load      (seed_load),
    .seed      (seed),
    .raw       (raw_bit),
    .seed_zero (seed_zero)
  );

  bal_tracker #(
    .HI_TH (HI_TH),
    .LO_TH (LO_TH),
    .BAL_W (BAL_W)
  ) u_trk (
    .clk      (clk),
    .rst_n    (rst_n),
    .adv      (advance),
    .clr      (seed_load),
    .raw      (raw_bit),
    .bit_out  (bit_out),
    .balance  (balance),
    .force_hi (force_hi),
    .force_lo (force_lo)
  );

endmodule

// File: rtl/bal_bitgen_chk.sv
module bal_bitgen_chk #(
  parameter int HI_TH = 4,
  parameter int LO_TH = -4,
  parameter int BAL_W = 4
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    en,
  input logic                    seed_load,
  input logic                    bit_out,
  input logic signed [BAL_W-1:0] balance,
  input logic                    raw_bit,
  input logic                    force_hi,
  input logic                    force_lo
);

  // R6
  balance_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(balance) <= HI_TH + 1) && (int'(balance) >= LO_TH - 1));

  // R3
  balance_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !seed_load) |=> (bit_out ? (balance == $past(balance) + BAL_W'(1))
                                    : (balance == $past(balance) - BAL_W'(1))));

  // R4
  clamp_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !seed_load && int'(balance) > HI_TH) |=> !bit_out);

  // R5
  clamp_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !seed_load && int'(balance) < LO_TH) |=> bit_out);

  // R10
  pass_raw_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !seed_load && !force_hi && !force_lo) |=> (bit_out == $past(raw_bit)));

  // R7
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !seed_load) |=> ($stable(balance) && $stable(bit_out)));

  // R8
  session_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seed_load |=> (balance == '0 && !bit_out));

endmodule

bind bal_bitgen bal_bitgen_chk #(
  .HI_TH (HI_TH),
  .LO_TH (LO_TH),
  .BAL_W (BAL_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .en        (en),
  .seed_load (seed_load),
  .bit_out   (bit_out),
  .balance   (balance),
  .raw_bit   (raw_bit),
  .force_hi  (force_hi),
  .force_lo  (force_lo)
);

// File: tb/tb_bal_bitgen.sv
module tb_bal_bitgen;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              en = 1'b0;
  logic              seed_load = 1'b0;
  logic [22:0]       seed = '0;
  logic              bit_out;
  logic signed [3:0] balance;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  // Bench model: separate tallies of ones and zeros, plus a bit-array register.
  bit [22:0] m_reg;
  int        m_ones, m_zeros;
  bit        m_bit;
  int        hits_hi, hits_lo;

  always #5 clk = ~clk;

  bal_bitgen dut (
    .clk(clk), .rst_n(rst_n), .en(en), .seed_load(seed_load),
    .seed(seed), .bit_out(bit_out), .balance(balance)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic model_clear(input bit [22:0] s);
    m_reg   = (s == 0) ? 23'd1 : s;
    m_ones  = 0;
    m_zeros = 0;
    m_bit   = 1'b0;
  endtask

  // One clock: drive at negedge, model the edge, compare at the next negedge.
  task automatic step(input bit e, input bit ld, input bit [22:0] s, input string req);
    string tag;
    int    d;
    bit    r, fb;
    en = e; seed_load = ld; seed = s;
    @(negedge clk);
    tag = req;
    if (ld) begin
      model_clear(s);
    end else if (e) begin
      d  = m_ones - m_zeros;
      r  = m_reg[22];
      if (d >= 5)       begin m_bit = 1'b0; tag = "R4"; hits_hi++; end
      else if (d <= -5) begin m_bit = 1'b1; tag = "R5"; hits_lo++; end
      else              m_bit = r;
      if (m_bit) m_ones++; else m_zeros++;
      fb    = m_reg[22] ^ m_reg[17];
      m_reg = {m_reg[21:0], fb};
    end
    check(bit_out == m_bit, tag, int'(bit_out), int'(m_bit));
    check(int'(balance) == m_ones - m_zeros, "R3", int'(balance), m_ones - m_zeros);
    check(int'(balance) <= 5 && int'(balance) >= -5, "R6", int'(balance), 5);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; en = 0; seed_load = 0;
    repeat (2) @(negedge clk);
    model_clear(23'd1);
    check(bit_out == 1'b0, "R1", int'(bit_out), 0);
    check(balance == 0, "R1", int'(balance), 0);
    rst_n = 1'b1;
    // default seed 1 gives 22 raw zeros then a one: R2/R1 stream check
    for (int i = 0; i < 30; i++) step(1, 0, 0, "R2");
  endtask

  task automatic t_high_clamp();
    int h0;
    h0 = hits_hi;
    step(1, 1, 23'h7FFFFF, "R8");
    for (int i = 0; i < 40; i++) step(1, 0, 0, "R10");
    check(hits_hi > h0 + 5, "R4", hits_hi - h0, 6);
  endtask

  task automatic t_low_clamp();
    int l0;
    l0 = hits_lo;
    step(1, 1, 23'h000001, "R8");
    for (int i = 0; i < 40; i++) step(1, 0, 0, "R10");
    check(hits_lo > l0 + 5, "R5", hits_lo - l0, 6);
  endtask

  task automatic t_zero_seed();
    step(1, 1, 23'h0, "R9");
    for (int i = 0; i < 40; i++) step(1, 0, 0, "R9");
  endtask

  task automatic t_idle_hold();
    step(1, 1, 23'h2A5C31, "R8");
    for (int i = 0; i < 7; i++) step(1, 0, 0, "R2");
    for (int i = 0; i < 6; i++) step(0, 0, 23'h123456, "R7");
    // stream must resume exactly where it stopped
    for (int i = 0; i < 30; i++) step(1, 0, 0, "R7");
  endtask

  task automatic t_load_priority();
    for (int i = 0; i < 5; i++) step(1, 0, 0, "R2");
    step(1, 1, 23'h0F0F0F, "R8");
    check(balance == 0 && bit_out == 1'b0, "R8", int'(balance), 0);
    for (int i = 0; i < 30; i++) step(1, 0, 0, "R2");
  endtask

  task automatic t_long_run();
    bit e;
    step(1, 1, 23'h3C1A77, "R8");
    for (int i = 0; i < 6000; i++) begin
      e = (i % 7) != 3;
      step(e, 0, 0, "R10");
    end
  endtask

  task automatic t_mid_reset();
    for (int i = 0; i < 8; i++) step(1, 0, 0, "R2");
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    model_clear(23'd1);
    check(bit_out == 1'b0 && balance == 0, "R1", int'(balance), 0);
    rst_n = 1'b1;
    for (int i = 0; i < 30; i++) step(1, 0, 0, "R1");
  endtask

  initial begin
    hits_hi = 0; hits_lo = 0;
    model_clear(23'd1);
    t_reset();
    t_high_clamp();
    t_low_clamp();
    t_zero_seed();
    t_idle_hold();
    t_load_priority();
    t_long_run();
    t_mid_reset();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    for (int c = 0; c < 100000; c++) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule